// File: doc/BRIEF.md
# Prioritised Interrupt Request Resolver

This block watches eight interrupt request lines and decides which one the processor should service next. It keeps four registers: the captured requests, the levels currently in service, a mask, and a per-line choice between edge and level retention. Line 0 has the highest priority and line 7 the lowest. The block latches the highest-priority unmasked request that no active service of equal or higher priority blocks. It then holds its interrupt output high until the processor acknowledges.

An acknowledge pulse returns an 8-bit vector. The vector is the programmed base byte with the granted level in its low three bits. The pulse also updates the request and in-service registers. A command decoder next to the block drives the rest as plain strobes: end-of-interrupt commands (lowest in-service level, or a given level), mask and edge/level writes, an initialisation clear, and two mode flags. The auto-EOI flag skips the in-service bookkeeping. The special mask mode flag lets masked in-service levels stop blocking.

There is no back-pressure on the vector path. `vec_valid_o` is high for exactly one cycle, the cycle after an acknowledge that met a latched request, and the consumer must take `vec_o` then. An acknowledge while `int_o` is low is dropped. If both end-of-interrupt strobes are high in the same cycle, the specific one is used.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Among request bits whose mask bit is 0 (mask bit 1 = masked), the lowest-numbered one wins; line 0 is the highest priority.
- R2: A winner is latched only if no in-service bit at its own level or a lower-numbered level is set; with the in-service register empty it is latched on the next clock.
- R3: When `smm_i` is 1, in-service bits of lines whose mask bit is 1 are ignored by the blocking test of R2.
- R4: A request bit is set when its line goes from 0 to 1. A line held at 1 sets nothing again. A line at 0 clears its request bit on the next clock.
- R5: On a granted acknowledge, the granted request bit is cleared when its edge/level bit is 0 (edge) and kept when it is 1 (level).
- R6: On a granted acknowledge, the granted in-service bit is set unless `auto_eoi_i` is 1, in which case the in-service register is unchanged.
- R7: One cycle after an acknowledge with `int_o` high, `vec_valid_o` is 1 and `vec_o` equals `base_i` OR the granted 3-bit level. An acknowledge with `int_o` low gives no `vec_valid_o`.
- R8: If the request register is all zero when a granted acknowledge arrives, `vec_o` is `base_i` OR 7, `int_o` drops, and the in-service register is not changed.
- R9: `eoi_ns_i` clears the lowest-numbered set in-service bit; `eoi_sp_i` clears the in-service bit numbered by `eoi_lvl_i`.
- R10: `int_o` stays 1 from latching until an acknowledge or clear. After an acknowledge, priority is evaluated again and a new winner can raise `int_o` on the following clock.
- R11: Reset and `init_clr_i` zero the request, in-service and line-state registers, set the mask to all ones and drop `int_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_clr_i | input | 1 | Initialisation clear strobe |
| irq_lines_i | input | 8 | Interrupt request lines, active high |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_d_i | input | 8 | Mask write data, 1 = line masked |
| lvl_we_i | input | 1 | Edge/level register write strobe |
| lvl_d_i | input | 8 | Edge/level write data, 1 = level retention |
| auto_eoi_i | input | 1 | Auto-EOI mode flag |
| smm_i | input | 1 | Special mask mode flag |
| base_i | input | 8 | Vector base byte |
| eoi_ns_i | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_sp_i | input | 1 | Specific end-of-interrupt strobe |
| eoi_lvl_i | input | 3 | Level cleared by a specific end-of-interrupt |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector returned on acknowledge |
| vec_valid_o | output | 1 | One-cycle qualifier for `vec_o` |
| req_o | output | 8 | Request register contents |
| isr_o | output | 8 | In-service register contents |
| mask_o | output | 8 | Mask register contents |

## Verification
Some properties are checked on every cycle. `int_o` is held until an acknowledge or clear. The vector only follows a real acknowledge, and it carries the base in its upper bits and 7 when spurious. A granted acknowledge sets exactly one new in-service bit, or none with auto-EOI. Request bits never outlive their line, and the clear leaves the reset state.

Other behaviour needs the bench's scenarios, because it depends on the history of several registers: the priority order, blocking by an in-service level and release by each kind of end-of-interrupt, the special-mask exception, level-mode retention followed by a spurious grant, and the dropped acknowledge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned DEF_LINES = 8;
  localparam int unsigned DEF_VEC_W = 8;

  typedef enum logic [1:0] {
    EOI_NONE   = 2'd0,
    EOI_LOWEST = 2'd1,
    EOI_LEVEL  = 2'd2
  } eoi_kind_e;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_clr_i,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] line_q;
  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  assign rise = lines_i & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      req_q  <= '0;
    end else if (init_clr_i) begin
      line_q <= '0;
      req_q  <= '0;
    end else begin
      line_q <= lines_i;
      req_q  <= ((req_q & ~ack_clr_i) | rise) & lines_i;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int unsigned N     = 8,
  localparam int unsigned LVL_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     isr_i,
  input  logic             smm_i,
  output logic             raise_o,
  output logic [LVL_W-1:0] win_lvl_o
);
  logic [N-1:0]     enabled;
  logic [N-1:0]     isr_eff;
  logic             win_vld;
  logic [LVL_W-1:0] win_lvl;
  logic             blocked;

  assign enabled = req_i & ~mask_i;
  assign isr_eff = smm_i ? (isr_i & ~mask_i) : isr_i;

  always_comb begin
    win_vld = 1'b0;
    win_lvl = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (enabled[i]) begin
        win_vld = 1'b1;
        win_lvl = LVL_W'(i);
      end
    end
  end

  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (isr_eff[i] && (LVL_W'(i) <= win_lvl)) blocked = 1'b1;
    end
  end

  assign raise_o   = win_vld & ~blocked;
  assign win_lvl_o = win_lvl;
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track
  import irq_prio_pkg::*;
#(
  parameter int unsigned N     = 8,
  localparam int unsigned LVL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_clr_i,
  input  eoi_kind_e        eoi_kind_i,
  input  logic [LVL_W-1:0] eoi_lvl_i,
  input  logic [N-1:0]     set_i,
  output logic [N-1:0]     isr_o
);
  logic [N-1:0] isr_q;
  logic [N-1:0] clr;

  always_comb begin
    unique case (eoi_kind_i)
      EOI_LOWEST: clr = isr_q & ~(isr_q - N'(1));
      EOI_LEVEL:  clr = N'(1) << eoi_lvl_i;
      default:    clr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr_q <= '0;
    else if (init_clr_i) isr_q <= '0;
    else                 isr_q <= (isr_q & ~clr) | set_i;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LINES = DEF_LINES,
  parameter int unsigned VEC_W     = DEF_VEC_W,
  localparam int unsigned LVL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_clr_i,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_d_i,
  input  logic                 lvl_we_i,
  input  logic [NUM_LINES-1:0] lvl_d_i,
  input  logic                 auto_eoi_i,
  input  logic                 smm_i,
  input  logic [VEC_W-1:0]     base_i,
  input  logic                 eoi_ns_i,
  input  logic                 eoi_sp_i,
  input  logic [LVL_W-1:0]     eoi_lvl_i,
  input  logic                 ack_i,
  output logic                 int_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o,
  output logic [NUM_LINES-1:0] req_o,
  output logic [NUM_LINES-1:0] isr_o,
  output logic [NUM_LINES-1:0] mask_o
);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] lvl_q;
  logic                 pend_q;
  logic [LVL_W-1:0]     pend_lvl_q;
  logic [VEC_W-1:0]     vec_q;
  logic                 vec_vld_q;

  logic [NUM_LINES-1:0] req;
  logic [NUM_LINES-1:0] isr;
  logic                 raise;
  logic [LVL_W-1:0]     win_lvl;
  logic                 grant;
  logic                 spur;
  logic [NUM_LINES-1:0] gnt_oh;
  logic [NUM_LINES-1:0] ack_clr;
  logic [NUM_LINES-1:0] isr_set;
  eoi_kind_e            eoi_kind;

  assign grant   = ack_i && pend_q && !init_clr_i;
  assign spur    = grant && (req == '0);
  assign gnt_oh  = NUM_LINES'(1) << pend_lvl_q;
  assign ack_clr = (grant && !spur) ? (gnt_oh & ~lvl_q) : '0;
  assign isr_set = (grant && !spur && !auto_eoi_i) ? gnt_oh : '0;

  always_comb begin
    if (eoi_sp_i)      eoi_kind = EOI_LEVEL;
    else if (eoi_ns_i) eoi_kind = EOI_LOWEST;
    else               eoi_kind = EOI_NONE;
  end

  irq_req_capture #(.N(NUM_LINES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_clr_i (init_clr_i),
    .lines_i    (irq_lines_i),
    .ack_clr_i  (ack_clr),
    .req_o      (req)
  );

  irq_prio_resolve #(.N(NUM_LINES)) u_res (
    .req_i     (req),
    .mask_i    (mask_q),
    .isr_i     (isr),
    .smm_i     (smm_i),
    .raise_o   (raise),
    .win_lvl_o (win_lvl)
  );

  irq_service_track #(.N(NUM_LINES)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_clr_i (init_clr_i),
    .eoi_kind_i (eoi_kind),
    .eoi_lvl_i  (eoi_lvl_i),
    .set_i      (isr_set),
    .isr_o      (isr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      lvl_q  <= '0;
    end else begin
      if (init_clr_i)     mask_q <= '1;
      else if (mask_we_i) mask_q <= mask_d_i;
      if (lvl_we_i)       lvl_q  <= lvl_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_lvl_q <= '0;
    end else if (init_clr_i || grant) begin
      pend_q     <= 1'b0;
    end else if (!pend_q && raise) begin
      pend_q     <= 1'b1;
      pend_lvl_q <= win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q     <= '0;
      vec_vld_q <= 1'b0;
    end else begin
      vec_vld_q <= grant;
      if (grant) vec_q <= base_i | VEC_W'(spur ? SPUR_LVL : pend_lvl_q);
    end
  end

  assign int_o       = pend_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vec_vld_q;
  assign req_o       = req;
  assign isr_o       = isr;
  assign mask_o      = mask_q;
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned VEC_W     = 8,
  localparam int unsigned LVL_W    = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 init_clr_i,
  input logic [NUM_LINES-1:0] irq_lines_i,
  input logic                 auto_eoi_i,
  input logic [VEC_W-1:0]     base_i,
  input logic                 eoi_ns_i,
  input logic                 eoi_sp_i,
  input logic                 ack_i,
  input logic                 int_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic                 vec_valid_o,
  input logic [NUM_LINES-1:0] req_o,
  input logic [NUM_LINES-1:0] isr_o,
  input logic [NUM_LINES-1:0] mask_o
);
  assert_int_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_o && !ack_i && !init_clr_i |=> int_o);

  assert_vec_follows_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(ack_i) && $past(int_o));

  assert_vec_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> vec_o[VEC_W-1:LVL_W] == $past(base_i[VEC_W-1:LVL_W]));

  assert_spurious_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && int_o && !init_clr_i && (req_o == '0) |=> (vec_o[LVL_W-1:0] == '1) && !int_o);

  assert_isr_one_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && int_o && !init_clr_i && (req_o != '0) && !auto_eoi_i && !eoi_ns_i && !eoi_sp_i
    |=> $countones(isr_o & ~$past(isr_o)) == 1);

  assert_auto_eoi_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && int_o && auto_eoi_i |=> (isr_o & ~$past(isr_o)) == '0);

  assert_req_needs_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (req_o & ~$past(irq_lines_i)) == '0);

  assert_init_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr_i |=> (mask_o == '1) && (isr_o == '0) && !int_o);
endmodule

bind irq_prio_ctrl irq_prio_checker #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_clr_i  (init_clr_i),
  .irq_lines_i (irq_lines_i),
  .auto_eoi_i  (auto_eoi_i),
  .base_i      (base_i),
  .eoi_ns_i    (eoi_ns_i),
  .eoi_sp_i    (eoi_sp_i),
  .ack_i       (ack_i),
  .int_o       (int_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .req_o       (req_o),
  .isr_o       (isr_o),
  .mask_o      (mask_o)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_clr = 1'b0;
  logic [7:0] lines = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_d = '0;
  logic       lvl_we = 1'b0;
  logic [7:0] lvl_d = '0;
  logic       auto_eoi = 1'b0;
  logic       smm = 1'b0;
  logic [7:0] base = '0;
  logic       eoi_ns = 1'b0;
  logic       eoi_sp = 1'b0;
  logic [2:0] eoi_lvl = '0;
  logic       ack = 1'b0;
  logic       int_o;
  logic [7:0] vec;
  logic       vec_valid;
  logic [7:0] req;
  logic [7:0] isr;
  logic [7:0] mask;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .init_clr_i(init_clr), .irq_lines_i(lines),
    .mask_we_i(mask_we), .mask_d_i(mask_d), .lvl_we_i(lvl_we), .lvl_d_i(lvl_d),
    .auto_eoi_i(auto_eoi), .smm_i(smm), .base_i(base), .eoi_ns_i(eoi_ns),
    .eoi_sp_i(eoi_sp), .eoi_lvl_i(eoi_lvl), .ack_i(ack), .int_o(int_o),
    .vec_o(vec), .vec_valid_o(vec_valid), .req_o(req), .isr_o(isr), .mask_o(mask)
  );

  // Each entry: {lines, mask, base, expected vector}
  localparam logic [31:0] TBL [5] = '{
    {8'hA4, 8'h00, 8'h20, 8'h22},
    {8'hF0, 8'h10, 8'h08, 8'h0D},
    {8'h81, 8'h01, 8'h40, 8'h47},
    {8'h01, 8'h00, 8'h70, 8'h70},
    {8'h18, 8'h08, 8'hC0, 8'hC4}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_init();
    init_clr = 1'b1; step(1); init_clr = 1'b0; step(1);
  endtask

  task automatic wr_mask(input logic [7:0] v);
    mask_d = v; mask_we = 1'b1; step(1); mask_we = 1'b0;
  endtask

  task automatic wr_lvl(input logic [7:0] v);
    lvl_d = v; lvl_we = 1'b1; step(1); lvl_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R11 reset int", {7'd0, int_o}, 8'h00);
    chk("R11 reset mask", mask, 8'hFF);
    chk("R11 reset req", req, 8'h00);
    chk("R11 reset isr", isr, 8'h00);
    chk("R7 reset vec_valid", {7'd0, vec_valid}, 8'h00);

    // Table walk: priority and vector forming
    for (int k = 0; k < 5; k++) begin
      do_init();
      wr_mask(TBL[k][23:16]);
      base = TBL[k][15:8];
      lines = TBL[k][31:24];
      step(3);
      chk("R1 table int", {7'd0, int_o}, 8'h01);
      do_ack();
      chk("R7 table vec_valid", {7'd0, vec_valid}, 8'h01);
      chk("R1 R7 table vec", vec, TBL[k][7:0]);
      lines = '0;
      step(2);
    end

    // Edge capture, blocking, EOI kinds
    do_init(); wr_mask(8'h00); base = 8'h30;
    lines[3] = 1'b1; step(1);
    chk("R4 rise sets req", req, 8'h08);
    step(2);
    chk("R2 empty isr raises", {7'd0, int_o}, 8'h01);
    do_ack();
    chk("R7 vec lvl3", vec, 8'h33);
    chk("R5 edge req cleared", req, 8'h00);
    chk("R6 isr set", isr, 8'h08);
    step(3);
    chk("R4 held line no re-set", req, 8'h00);
    lines[5] = 1'b1; step(3);
    chk("R4 lower req captured", req, 8'h20);
    chk("R2 lower blocked", {7'd0, int_o}, 8'h00);
    lines[1] = 1'b1; step(3);
    chk("R2 higher raised", {7'd0, int_o}, 8'h01);
    do_ack();
    chk("R1 vec lvl1", vec, 8'h31);
    chk("R6 isr two bits", isr, 8'h0A);
    step(2);
    chk("R10 re-eval still blocked", {7'd0, int_o}, 8'h00);
    eoi_ns = 1'b1; step(1); eoi_ns = 1'b0;
    chk("R9 nonspecific clears lowest", isr, 8'h08);
    step(2);
    chk("R2 blocked by level 3", {7'd0, int_o}, 8'h00);
    eoi_lvl = 3'd3; eoi_sp = 1'b1; step(1); eoi_sp = 1'b0;
    chk("R9 specific clears level", isr, 8'h00);
    step(2);
    chk("R2 released", {7'd0, int_o}, 8'h01);
    do_ack();
    chk("R7 vec lvl5", vec, 8'h35);
    lines = '0; step(2);
    chk("R4 deassert clears req", req, 8'h00);
    chk("R6 isr lvl5", isr, 8'h20);

    // Special mask mode
    do_init(); wr_mask(8'h00); base = 8'h50;
    lines = 8'h04; step(3); do_ack();
    chk("R3 setup vec", vec, 8'h52);
    wr_mask(8'h04);
    lines = 8'h44; step(3);
    chk("R3 smm off blocks", {7'd0, int_o}, 8'h00);
    smm = 1'b1; step(2);
    chk("R3 smm on raises", {7'd0, int_o}, 8'h01);
    do_ack();
    chk("R3 vec lvl6", vec, 8'h56);
    smm = 1'b0; lines = '0; step(2);

    // Level retention, auto-EOI, spurious
    do_init(); wr_lvl(8'h10); wr_mask(8'h00); auto_eoi = 1'b1; base = 8'h60;
    lines = 8'h10; step(3); do_ack();
    chk("R7 vec lvl4", vec, 8'h64);
    chk("R5 level req kept", req, 8'h10);
    chk("R6 auto-eoi isr", isr, 8'h00);
    step(2);
    chk("R10 re-raise after ack", {7'd0, int_o}, 8'h01);
    lines = '0; step(1);
    chk("R4 level deassert clears", req, 8'h00);
    chk("R10 int held", {7'd0, int_o}, 8'h01);
    do_ack();
    chk("R8 spurious vec", vec, 8'h67);
    chk("R8 int dropped", {7'd0, int_o}, 8'h00);
    chk("R8 isr untouched", isr, 8'h00);
    auto_eoi = 1'b0; wr_lvl(8'h00); step(2);
    do_ack();
    chk("R7 ack ignored no valid", {7'd0, vec_valid}, 8'h00);
    chk("R7 ack ignored isr", isr, 8'h00);

    // Initialisation clear mid-state
    lines = 8'h01; step(3); do_ack();
    chk("R6 pre-init isr", isr, 8'h01);
    init_clr = 1'b1; step(1); init_clr = 1'b0;
    chk("R11 init isr", isr, 8'h00);
    chk("R11 init req", req, 8'h00);
    chk("R11 init mask", mask, 8'hFF);
    step(3);
    chk("R11 masked no int", {7'd0, int_o}, 8'h00);
    lines = '0; step(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule